// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Flag Adder

This block is the add and subtract datapath of a 64-bit fixed-point pipeline. It also produces the carry and overflow bits of a 32-bit exception-status register. Each operation forms `X + Y + c0` from two 64-bit operands. The operation code selects the operands and the carry-in:

- plain add: `A + B`
- extended add: `A + B + carry_in`
- subtract-from: `~A + B + 1`
- extended subtract-from: `~A + B + carry_in`

A single 65-bit adder produces the sum. Carry and overflow are then read at two widths. The full-width pair comes from bit 63. The narrow pair comes from bit 31, by tapping the carries into and out of that bit position. No second adder is used.

The caller supplies the current status register value on `stat_in`. The block returns the updated value on `stat_out`, and the caller writes it back. The carry fields change only when `ca_en` is high, and the overflow fields only when `ov_en` is high. The summary-overflow bit is sticky: it can be set but never cleared here. All other bits of the register are copied through unchanged.

Results are registered. A small controller has two states:

- `S_IDLE`: no result is being presented.
- `S_DONE`: the registered result is valid.

Its transitions are:

- `T_ACCEPT`: `S_IDLE` to `S_DONE` on `in_valid`.
- `T_CHAIN`: `S_DONE` to `S_DONE` on `in_valid`.
- `T_RETIRE`: `S_DONE` to `S_IDLE` when `in_valid` is low.

Top module: `cof_unit`

## Requirements
- R1: After reset, `result` is 0, `stat_out` is 0 and `out_valid` is 0.
- R2: For `op`=0 (plain add), `result` equals `a + b` modulo 2^64. `result` and `out_valid`=1 appear on the first clock edge after the edge that samples `in_valid`=1. `out_valid` returns to 0 one edge after `in_valid` drops.
- R3: For `op`=2, `result` equals `~a + b + 1` modulo 2^64.
- R4: For `op`=1 the carry-in is `carry_in` on `a + b`, and for `op`=3 it is `carry_in` on `~a + b`. `op`=0 ignores `carry_in`.
- R5: With `ca_en`=1, `stat_out` bit 29 equals the carry out of bit 63 of the sum.
- R6: With `ca_en`=1, `stat_out` bit 18 equals the carry out of bit 31 of the same sum.
- R7: With `ov_en`=1, `stat_out` bit 30 is the signed 64-bit overflow of the addition. When that overflow occurs, bit 31 is also set.
- R8: With `ov_en`=1 and no 64-bit overflow, bit 30 is cleared and bit 31 keeps the value of `stat_in` bit 31.
- R9: With `ov_en`=1, `stat_out` bit 19 is the signed overflow of the low 32 bits alone. It does not affect bit 31.
- R10: With `ca_en`=0, bits 29 and 18 copy `stat_in`. With `ov_en`=0, bits 31, 30 and 19 copy `stat_in`.
- R11: All `stat_out` bits other than 31, 30, 29, 19 and 18 copy `stat_in`.
- R12: While `in_valid` is 0, `result` and `stat_out` hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 add, 1 extended add, 2 subtract-from, 3 extended subtract-from |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| carry_in | input | 1 | Carry used by the extended operations |
| ca_en | input | 1 | Allow update of the carry fields |
| ov_en | input | 1 | Allow update of the overflow fields |
| stat_in | input | 32 | Current status register value |
| result | output | 64 | Registered sum |
| stat_out | output | 32 | Registered updated status value |
| out_valid | output | 1 | Result valid (controller in `S_DONE`) |

## Verification
Every result of this block is due one clock edge after its strobe. This covers the sum, all five status fields and `out_valid`. The bench drives each operation on a falling edge and holds the strobe for one cycle. It then reads all outputs on the next falling edge, which lies half a period after the single capturing edge. The hold check drops the strobe and scrambles the inputs, then reads again after several further edges. It confirms that nothing moved and that `out_valid` fell exactly one edge after the strobe ended.

// File: rtl/cof_pkg.sv
package cof_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = 32;
    localparam int STAT_W = 32;

    // Status field positions (consumed by downstream logic)
    localparam int BIT_SO   = 31;
    localparam int BIT_OV   = 30;
    localparam int BIT_CA   = 29;
    localparam int BIT_OV32 = 19;
    localparam int BIT_CA32 = 18;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_ADDX  = 2'd1,
        OP_SUBF  = 2'd2,
        OP_SUBFX = 2'd3
    } op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/cof_opsel.sv
module cof_opsel #(
    parameter int W = 64
) (
    input  cof_pkg::op_e   op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_in,
    output logic [W-1:0]   x,
    output logic [W-1:0]   y,
    output logic           c0
);
    import cof_pkg::*;

    always_comb begin
        y = b;
        unique case (op)
            OP_ADD:   begin x = a;  c0 = 1'b0;     end
            OP_ADDX:  begin x = a;  c0 = carry_in; end
            OP_SUBF:  begin x = ~a; c0 = 1'b1;     end
            OP_SUBFX: begin x = ~a; c0 = carry_in; end
            default:  begin x = a;  c0 = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/cof_adder.sv
module cof_adder #(
    parameter int W = 64,
    parameter int H = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         co_full,
    output logic         ov_full,
    output logic         co_half,
    output logic         ov_half
);
    logic [W:0] wide;
    logic       cin_top;
    logic       cin_half_top;

    assign wide    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
    assign sum     = wide[W-1:0];
    assign co_full = wide[W];

    // Carry into a bit position is recovered as sum ^ x ^ y at that bit
    assign cin_top      = sum[W-1] ^ x[W-1] ^ y[W-1];
    assign ov_full      = co_full ^ cin_top;
    assign co_half      = sum[H] ^ x[H] ^ y[H];
    assign cin_half_top = sum[H-1] ^ x[H-1] ^ y[H-1];
    assign ov_half      = co_half ^ cin_half_top;
endmodule

// File: rtl/cof_flags.sv
module cof_flags #(
    parameter int SW = 32
) (
    input  logic [SW-1:0] stat_in,
    input  logic          ca_en,
    input  logic          ov_en,
    input  logic          ca,
    input  logic          ca32,
    input  logic          ov,
    input  logic          ov32,
    output logic [SW-1:0] stat_next
);
    import cof_pkg::*;

    always_comb begin
        stat_next = stat_in;
        if (ca_en) begin
            stat_next[BIT_CA]   = ca;
            stat_next[BIT_CA32] = ca32;
        end
        if (ov_en) begin
            stat_next[BIT_OV]   = ov;
            stat_next[BIT_OV32] = ov32;
            stat_next[BIT_SO]   = stat_in[BIT_SO] | ov;
        end
    end
endmodule

// File: rtl/cof_unit.sv
module cof_unit #(
    parameter int DW = cof_pkg::DATA_W,
    parameter int HW = cof_pkg::HALF_W,
    parameter int SW = cof_pkg::STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    input  logic          ca_en,
    input  logic          ov_en,
    input  logic [SW-1:0] stat_in,
    output logic [DW-1:0] result,
    output logic [SW-1:0] stat_out,
    output logic          out_valid
);
    import cof_pkg::*;

    localparam logic [SW-1:0] FIELD_MASK =
        (SW'(1) << BIT_SO) | (SW'(1) << BIT_OV) | (SW'(1) << BIT_CA) |
        (SW'(1) << BIT_OV32) | (SW'(1) << BIT_CA32);

    ctl_state_e    state_q, state_d;
    logic [DW-1:0] x, y, sum;
    logic          c0, co_full, ov_full, co_half, ov_half;
    logic [SW-1:0] stat_next;

    cof_opsel #(.W(DW)) u_opsel (
        .op(op_e'(op)), .a(opnd_a), .b(opnd_b), .carry_in(carry_in),
        .x(x), .y(y), .c0(c0)
    );

    cof_adder #(.W(DW), .H(HW)) u_adder (
        .x(x), .y(y), .c0(c0), .sum(sum),
        .co_full(co_full), .ov_full(ov_full),
        .co_half(co_half), .ov_half(ov_half)
    );

    cof_flags #(.SW(SW)) u_flags (
        .stat_in(stat_in), .ca_en(ca_en), .ov_en(ov_en),
        .ca(co_full), .ca32(co_half), .ov(ov_full), .ov32(ov_half),
        .stat_next(stat_next)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid) state_d = S_DONE;             // T_ACCEPT
            S_DONE: state_d = in_valid ? S_DONE : S_IDLE;        // T_CHAIN / T_RETIRE
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            stat_out <= '0;
        end else if (in_valid) begin
            result   <= sum;
            stat_out <= stat_next;
        end
    end

    assign out_valid = (state_q == S_DONE);

    // Assertions
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_ov_implies_so: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ov_en) |=> (!stat_out[BIT_OV] || stat_out[BIT_SO]));
    a_r8_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stat_in[BIT_SO]) |=> stat_out[BIT_SO]);
    a_r10_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ca_en) |=>
            (stat_out[BIT_CA] == $past(stat_in[BIT_CA]) &&
             stat_out[BIT_CA32] == $past(stat_in[BIT_CA32])));
    a_r11_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((stat_out & ~FIELD_MASK) == ($past(stat_in) & ~FIELD_MASK)));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(stat_out)));
endmodule

// File: tb/test_cof_unit.sv
module test_cof_unit;
    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic        cin;
        logic        cae;
        logic        ove;
        logic [31:0] sin;
        logic [63:0] res;
        logic [31:0] sout;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    // Field values: SO 8000_0000, OV 4000_0000, CA 2000_0000, OV32 0008_0000, CA32 0004_0000
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'd1, 64'd2, 1'b0, 1'b1, 1'b1, 32'h0, 64'd3, 32'h0, 8'd2},                                          // R2
        '{2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 1'b1, 32'h0, 64'h0000_0001_0000_0000, 32'h0004_0000, 8'd6}, // R6
        '{2'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 1'b1, 1'b1, 32'h0, 64'h0000_0000_8000_0000, 32'h0008_0000, 8'd9}, // R9
        '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 1'b1, 32'h0, 64'h0, 32'h2004_0000, 8'd5},                  // R5
        '{2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 1'b1, 32'h0, 64'h8000_0000_0000_0000, 32'hC004_0000, 8'd7}, // R7
        '{2'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 32'h0, 64'h7FFF_FFFF_FFFF_FFFF, 32'hE000_0000, 8'd7}, // R7
        '{2'd0, 64'd1, 64'd2, 1'b0, 1'b1, 1'b1, 32'hC000_0000, 64'd3, 32'h8000_0000, 8'd8},                           // R8
        '{2'd2, 64'd5, 64'd9, 1'b0, 1'b1, 1'b1, 32'h0, 64'd4, 32'h2004_0000, 8'd3},                                   // R3
        '{2'd2, 64'd9, 64'd5, 1'b0, 1'b1, 1'b1, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, 32'h0, 8'd3},                         // R3
        '{2'd1, 64'd1, 64'd2, 1'b1, 1'b1, 1'b1, 32'h0, 64'd4, 32'h0, 8'd4},                                           // R4
        '{2'd3, 64'd5, 64'd9, 1'b0, 1'b1, 1'b1, 32'h0, 64'd3, 32'h2004_0000, 8'd4},                                   // R4
        '{2'd0, 64'd1, 64'd2, 1'b1, 1'b1, 1'b1, 32'h0, 64'd3, 32'h0, 8'd4},                                           // R4
        '{2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b0, 32'h2004_0000, 64'h8000_0000_0000_0000, 32'h2004_0000, 8'd10}, // R10
        '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 1'b0, 32'h4008_0000, 64'h0, 32'h600C_0000, 8'd10},       // R10
        '{2'd0, 64'd1, 64'd2, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 64'd3, 32'h1230_5678, 8'd11}                           // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        carry_in = 1'b0, ca_en = 1'b0, ov_en = 1'b0;
    logic [31:0] stat_in = '0;
    logic [63:0] result;
    logic [31:0] stat_out;
    logic        out_valid;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cof_unit i_cof_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .ca_en(ca_en), .ov_en(ov_en), .stat_in(stat_in),
        .result(result), .stat_out(stat_out), .out_valid(out_valid)
    );

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1; op = v.op; opnd_a = v.a; opnd_b = v.b;
        carry_in = v.cin; ca_en = v.cae; ov_en = v.ove; stat_in = v.sin;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk64("R1 result", result, 64'h0);
        chk64("R1 stat_out", {32'h0, stat_out}, 64'h0);
        chk64("R1 out_valid", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            chk64($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].res);
            chk64($sformatf("R%0d vec%0d stat", VECS[i].req, i), {32'h0, stat_out}, {32'h0, VECS[i].sout});
            chk64($sformatf("R2 vec%0d out_valid", i), {63'h0, out_valid}, 64'h1);
        end

        // R12 hold while idle, and R2 valid drop
        apply(VECS[4]);
        opnd_a = 64'hDEAD_BEEF_0000_1111; opnd_b = 64'h5555; stat_in = 32'hFFFF_FFFF;
        ca_en = 1'b1; ov_en = 1'b1; op = 2'd2;
        @(negedge clk);
        chk64("R2 out_valid drop", {63'h0, out_valid}, 64'h0);
        repeat (4) @(negedge clk);
        chk64("R12 result hold", result, 64'h8000_0000_0000_0000);
        chk64("R12 stat hold", {32'h0, stat_out}, 64'hC004_0000);

        // R2 back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; op = 2'd0; opnd_a = 64'd10; opnd_b = 64'd20; stat_in = 32'h0;
        @(negedge clk);
        chk64("R2 chain first", result, 64'd30);
        opnd_a = 64'd100;
        @(negedge clk);
        in_valid = 1'b0;
        chk64("R2 chain second", result, 64'd120);
        chk64("R2 chain valid", {63'h0, out_valid}, 64'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule